// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits beside a CPU core. It watches three external interrupt pins and turns activity on them into interrupt requests. Each pin runs through a two-stage synchronizer and a held previous sample. The configured trigger condition on a pin either sets a sticky request flag (edge modes) or drives the request directly for as long as the pin is low (level mode). Channels 0 and 1 can be set to a low level, a falling edge or a rising edge. Channel 2 can only be set to an edge, and one sense bit selects its direction.

Software uses a small register bus with three registers: sense control, channel enables and request flags. A set flag is cleared by writing a one to it, or by the CPU acknowledging the interrupt it was given. The CPU sees a single request line and a word vector address. The vector picks the lowest-numbered pending channel, but only when the global interrupt enable input and that channel's enable bit are both set.

For software-raised interrupts, a pin configured as an output is fed back into the detector. A separate wake output is purely combinational, so it responds even while the clock is stopped.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three registers read zero, `irq_req` is 0, `irq_vec` is 0 and `wake` is 0 while the pins are high.
- R2: Channels 0 and 1 use a 2-bit sense field at register address 0: channel 0 in bits [1:0], channel 1 in bits [3:2]. Code 10 sets the flag on a falling edge and code 11 on a rising edge. The flag is visible on the third rising clock edge after the pin changes. An edge of the opposite direction sets nothing.
- R3: Sense code 01 on channel 0 or 1 disables that channel: pin activity sets no flag and raises no request.
- R4: Sense code 00 is low level. The channel requests while its synchronized pin is low, starting at the second clock edge after the pin falls and stopping at the second edge after it rises. Its flag is never set.
- R5: Channel 2's sense bit (bit 4 of address 0) selects a falling edge when 0 and a rising edge when 1. The edge of the other direction sets nothing.
- R6: A pending channel drives `irq_req` only when `gie` is 1 and its enable bit is set. The enables are at address 1: bit 6 for channel 0, bit 7 for channel 1, bit 5 for channel 2. A flag is still set and readable while its channel is disabled.
- R7: The flags are at address 2: bit 6 for channel 0, bit 7 for channel 1, bit 5 for channel 2. Writing a one to a flag bit clears that flag. Writing zero leaves it unchanged.
- R8: `irq_ack` held high for one clock clears the flag of the channel whose vector is currently presented, and no other flag.
- R9: If a flag clear (write-one or acknowledge) and a new trigger event on the same channel fall in the same cycle, the flag stays set.
- R10: When `pin_oe[i]` is 1, the detector sees `pin_out[i]` instead of `pin_in[i]`, so software can raise an interrupt by driving the pin.
- R11: The vector is 0x002 for channel 0, 0x004 for channel 1 and 0x024 for channel 2, taken from the lowest-numbered requesting channel. The vector is 0x000 when there is no request.
- R12: `wake` is combinational and needs no clock. It is high when channel 0 or 1 is enabled, in level mode and its pin is low. It is also high when channel 2 is enabled and its pin differs from the last sampled value in the selected edge direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 3 | Pin levels from the pads |
| pin_out | input | 3 | Value software drives on each pin |
| pin_oe | input | 3 | Per-pin output enable; 1 selects pin_out for detection |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | One-cycle acknowledge of the presented vector |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 sense, 1 enable, 2 flags) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 10 | Word vector address of the request |
| wake | output | 1 | Clockless wake-up indication |

## Verification
A flag clear can fall in the same cycle as a new trigger on that channel. Clears come from a software write-one or from an acknowledge. The bench places a write-one clear exactly on the clock edge where the synchronized edge pulse reaches the flag: it changes the pin, waits two edges, and then issues the write. The flag must then still read as set, and a second identical write must clear it. The same rule holds for acknowledges, and an RTL property checks it for every channel. Random runs mix pin patterns, sense codes, enables and global enable, and compare flags, request and vector with a bench model.

// File: rtl/eis_pkg.sv
package eis_pkg;
    localparam int NCH   = 3;
    localparam int VEC_W = 10;

    localparam logic [1:0] SENSE_LOW  = 2'b00;
    localparam logic [1:0] SENSE_OFF  = 2'b01;
    localparam logic [1:0] SENSE_FALL = 2'b10;
    localparam logic [1:0] SENSE_RISE = 2'b11;

    localparam logic [1:0] A_SENSE  = 2'd0;
    localparam logic [1:0] A_ENABLE = 2'd1;
    localparam logic [1:0] A_FLAGS  = 2'd2;

    localparam logic [VEC_W-1:0] VEC_NONE = 10'h000;
    localparam logic [VEC_W-1:0] VEC_CH0  = 10'h002;
    localparam logic [VEC_W-1:0] VEC_CH1  = 10'h004;
    localparam logic [VEC_W-1:0] VEC_CH2  = 10'h024;

    typedef struct packed {
        logic [1:0]     sense0;
        logic [1:0]     sense1;
        logic           sense2;
        logic [NCH-1:0] en;
        logic [NCH-1:0] flag;
    } regs_t;

    // bit position of a channel inside the enable and flag registers
    function automatic int chan_bit(input int ch);
        case (ch)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] smp_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = pad_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    // pins idle high, so the pipeline resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign smp_o  = s_q.chain[STAGES-1];
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.chain[STAGES-1] & s_q.prev;

    // R2
    rise_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
    // R2
    fall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_o) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/eis_prio.sv
module eis_prio #(
    parameter int N  = 3,
    parameter int VW = 10
) (
    input  logic [N-1:0]         hit_i,
    input  logic [N-1:0][VW-1:0] tab_i,
    output logic [N-1:0]         grant_o,
    output logic                 any_o,
    output logic [VW-1:0]        vec_o
);
    always_comb begin
        grant_o = '0;
        vec_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                vec_o      = tab_i[i];
            end
        end
        any_o = |hit_i;
    end

    // R11
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant_o));
    end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pin_in,
    input  logic [NCH-1:0]   pin_out,
    input  logic [NCH-1:0]   pin_oe,
    input  logic             gie,
    input  logic             irq_ack,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             wake
);
    regs_t st_d, st_q;

    logic [NCH-1:0] pad, smp, rise, fall;
    logic [NCH-1:0] evt, is_lvl, pend, hit, grant, w1c, clr, wk;
    logic [1:0]     mode [NCH];
    logic [NCH-1:0][VEC_W-1:0] vec_tab;

    // R10: a driven pin feeds its own detector
    assign pad     = (pin_oe & pin_out) | (~pin_oe & pin_in);
    assign vec_tab = {VEC_CH2, VEC_CH1, VEC_CH0};

    eis_sync #(.STAGES(SYNC_STAGES), .W(NCH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad),
        .smp_o  (smp),
        .rise_o (rise),
        .fall_o (fall)
    );

    always_comb begin
        mode[0] = st_q.sense0;
        mode[1] = st_q.sense1;
        mode[2] = st_q.sense2 ? SENSE_RISE : SENSE_FALL;
        for (int i = 0; i < NCH; i++) begin
            evt[i]    = ((mode[i] == SENSE_FALL) && fall[i]) ||
                        ((mode[i] == SENSE_RISE) && rise[i]);
            is_lvl[i] = (mode[i] == SENSE_LOW);
            pend[i]   = is_lvl[i] ? ~smp[i] : st_q.flag[i];
            hit[i]    = pend[i] & st_q.en[i] & gie;
            if (i < NCH - 1) begin
                wk[i] = st_q.en[i] & is_lvl[i] & ~pad[i];
            end else begin
                wk[i] = st_q.en[i] & (st_q.sense2 ? (pad[i] & ~smp[i])
                                                  : (~pad[i] & smp[i]));
            end
        end
    end

    assign wake = |wk;

    eis_prio #(.N(NCH), .VW(VEC_W)) u_prio (
        .hit_i   (hit),
        .tab_i   (vec_tab),
        .grant_o (grant),
        .any_o   (irq_req),
        .vec_o   (irq_vec)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            w1c[i] = bus_we && (bus_addr == A_FLAGS) && bus_wdata[chan_bit(i)];
        end
        clr = w1c | (irq_ack ? grant : '0);
        if (bus_we && bus_addr == A_SENSE) begin
            st_d.sense0 = bus_wdata[1:0];
            st_d.sense1 = bus_wdata[3:2];
            st_d.sense2 = bus_wdata[4];
        end
        if (bus_we && bus_addr == A_ENABLE) begin
            for (int i = 0; i < NCH; i++) begin
                st_d.en[i] = bus_wdata[chan_bit(i)];
            end
        end
        // a new event outranks a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_SENSE: bus_rdata = {3'b000, st_q.sense2, st_q.sense1, st_q.sense0};
            A_ENABLE: begin
                for (int i = 0; i < NCH; i++) bus_rdata[chan_bit(i)] = st_q.en[i];
            end
            A_FLAGS: begin
                for (int i = 0; i < NCH; i++) bus_rdata[chan_bit(i)] = st_q.flag[i];
            end
            default: bus_rdata = '0;
        endcase
    end

    // R3 R4
    flag0_needs_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag[0]) |-> $past(st_q.sense0[1]));
    // R6
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);
    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FLAGS && bus_wdata[6] && !evt[0]) |=> !st_q.flag[0]);
    // R7
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag[0] && bus_we && bus_addr == A_FLAGS && !bus_wdata[6] && !irq_ack)
        |=> st_q.flag[0]);
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_vec == VEC_CH0 && !is_lvl[0] && !evt[0]) |=> !st_q.flag[0]);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q.flag & $past(evt)) == $past(evt)));
    // R11
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == VEC_CH0 || irq_vec == VEC_CH1 || irq_vec == VEC_CH2));
    // R11
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == VEC_NONE));
endmodule

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n;
    logic [2:0] pin_in, pin_out, pin_oe;
    logic       gie, irq_ack, bus_we;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq_req, wake;
    logic [9:0] irq_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 if (clk_run) clk = ~clk;

    ext_irq_sense u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .gie(gie), .irq_ack(irq_ack), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_vec(irq_vec), .wake(wake)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    // channel bits: 6 = ch0, 7 = ch1, 5 = ch2
    function automatic logic [7:0] map3(input logic [2:0] v);
        return {v[1], v[0], v[2], 5'b0};
    endfunction

    function automatic logic edge_hit(input logic [1:0] m, input logic o, input logic n);
        return (m == 2'b10 && o && !n) || (m == 2'b11 && !o && n);
    endfunction

    function automatic int vec_of(input logic [2:0] h);
        if (h[0]) return 'h002;
        if (h[1]) return 'h004;
        if (h[2]) return 'h024;
        return 0;
    endfunction

    task automatic flags_is(input string tag, input int exp);
        logic [7:0] d;
        rd(2'd2, d);
        chk(tag, d, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        rst_n = 1'b0; pin_in = 3'b111; pin_out = 3'b000; pin_oe = 3'b000;
        gie = 1'b0; irq_ack = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        rd(2'd0, d); chk("R1 sense", d, 0);
        rd(2'd1, d); chk("R1 enable", d, 0);
        flags_is("R1 flags", 0);
        chk("R1 req", irq_req, 0);
        chk("R1 vec", irq_vec, 0);
        chk("R1 wake", wake, 0);

        // R2 falling edge on ch0 with latency
        wr(2'd0, 8'h0A); wr(2'd1, 8'hE0); gie = 1'b1;
        pin_in[0] = 1'b0;
        tick(2); flags_is("R2 not before third edge", 0);
        tick(1); flags_is("R2 falling sets ch0", 'h40);
        chk("R11 vec ch0", irq_vec, 'h002);
        // R8 acknowledge
        ack();
        flags_is("R8 ack clears", 0);
        chk("R8 req drops", irq_req, 0);
        pin_in[0] = 1'b1; tick(4);
        flags_is("R2 opposite edge ignored", 0);

        // R10 software-driven pin on ch1
        pin_oe[1] = 1'b1; pin_out[1] = 1'b0; tick(3);
        flags_is("R10 driven pin sets ch1", 'h80);
        chk("R11 vec ch1", irq_vec, 'h004);
        pin_out[1] = 1'b1; tick(4); pin_oe[1] = 1'b0;
        wr(2'd2, 8'hE0);

        // R4 level on ch1
        wr(2'd0, 8'h02);
        pin_in[1] = 1'b0; tick(1);
        chk("R4 not yet", irq_req, 0);
        tick(1);
        chk("R4 level req", irq_req, 1);
        chk("R4 level vec", irq_vec, 'h004);
        flags_is("R4 no flag", 0);
        pin_in[1] = 1'b1; tick(2);
        chk("R4 level release", irq_req, 0);

        // R3 disabled code
        wr(2'd0, 8'h01);
        pin_in[0] = 1'b0; tick(4);
        chk("R3 no req low", irq_req, 0);
        pin_in[0] = 1'b1; tick(4);
        flags_is("R3 no flag", 0);
        chk("R3 no req", irq_req, 0);

        // R5 ch2 sense
        wr(2'd0, 8'h0A);
        pin_in[2] = 1'b0; tick(3);
        flags_is("R5 ch2 falling", 'h20);
        chk("R11 vec ch2", irq_vec, 'h024);
        wr(2'd2, 8'h20);
        pin_in[2] = 1'b1; tick(4);
        flags_is("R5 rise ignored in falling", 0);
        wr(2'd0, 8'h1A);
        pin_in[2] = 1'b0; tick(4);
        flags_is("R5 fall ignored in rising", 0);
        pin_in[2] = 1'b1; tick(3);
        flags_is("R5 ch2 rising", 'h20);

        // R6 gating
        gie = 1'b0; #0.5;
        chk("R6 gie off", irq_req, 0);
        flags_is("R6 flag kept", 'h20);
        gie = 1'b1; #0.5;
        chk("R6 gie on", irq_req, 1);
        wr(2'd1, 8'hC0);
        chk("R6 enable off", irq_req, 0);
        flags_is("R6 flag kept disabled", 'h20);
        wr(2'd1, 8'hE0);
        chk("R6 enable on", irq_req, 1);
        wr(2'd2, 8'h20);

        // R7 R8 R11 all three pending
        pin_in[2] = 1'b0; tick(4); wr(2'd2, 8'hE0);
        pin_in = 3'b100; tick(3);
        flags_is("R11 all set", 'hE0);
        chk("R11 lowest first", irq_vec, 'h002);
        wr(2'd2, 8'h00);
        flags_is("R7 zero write keeps", 'hE0);
        wr(2'd2, 8'h40);
        flags_is("R7 one clears ch0 only", 'hA0);
        chk("R11 next ch1", irq_vec, 'h004);
        ack();
        flags_is("R8 ack clears ch1 only", 'h20);
        chk("R11 then ch2", irq_vec, 'h024);
        ack();
        chk("R8 last ack", irq_req, 0);
        chk("R11 idle vec", irq_vec, 0);

        // R9 clear and event in the same cycle
        pin_in[2] = 1'b0; tick(4);
        pin_in[2] = 1'b1; tick(3);
        pin_in[2] = 1'b0; tick(4);
        flags_is("R9 precondition", 'h20);
        pin_in[2] = 1'b1; tick(2);
        wr(2'd2, 8'h20);
        flags_is("R9 set wins over clear", 'h20);
        wr(2'd2, 8'h20);
        flags_is("R7 plain clear", 0);

        // R12 wake without clock
        pin_in = 3'b111; tick(4); wr(2'd2, 8'hE0);
        wr(2'd0, 8'h18);
        pin_in[2] = 1'b0; tick(4);
        chk("R12 idle", wake, 0);
        clk_run = 1'b0;
        pin_in[0] = 1'b0; #2;
        chk("R12 level low wakes", wake, 1);
        pin_in[0] = 1'b1; #2;
        chk("R12 level high no wake", wake, 0);
        pin_in[2] = 1'b1; #2;
        chk("R12 ch2 edge wakes", wake, 1);
        clk_run = 1'b1;
        tick(3);
        flags_is("R12 flag after clock resumes", 'h20);
        wr(2'd2, 8'hE0);

        // random mix: R2 R3 R4 R5 R6 R11
        for (int it = 0; it < 60; it++) begin
            logic [1:0] m0, m1;
            logic       s2, g;
            logic [2:0] en, o, n, ef, pd, h;
            logic [1:0] m2;
            m0 = 2'($urandom % 4); m1 = 2'($urandom % 4); s2 = 1'($urandom % 2);
            en = 3'($urandom % 8); g = 1'($urandom % 2);
            o = 3'($urandom % 8); n = 3'($urandom % 8);
            pin_in = o; tick(4);
            wr(2'd0, {3'b000, s2, m1, m0});
            wr(2'd1, map3(en));
            gie = g;
            wr(2'd2, 8'hE0);
            pin_in = n; tick(4);
            m2 = s2 ? 2'b11 : 2'b10;
            ef[0] = edge_hit(m0, o[0], n[0]);
            ef[1] = edge_hit(m1, o[1], n[1]);
            ef[2] = edge_hit(m2, o[2], n[2]);
            pd[0] = (m0 == 2'b00) ? !n[0] : ef[0];
            pd[1] = (m1 == 2'b00) ? !n[1] : ef[1];
            pd[2] = ef[2];
            h = pd & en & {3{g}};
            flags_is("R2 R5 random flags", map3(ef));
            chk("R6 random req", irq_req, |h);
            chk("R11 random vec", irq_vec, vec_of(h));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule